// File: doc/BRIEF.md
# DMA Line-Splitting Request Queue

This block is the command front end of a DMA engine that serves a processing element with a private local memory. Software pushes transfer requests into an in-order queue. Each request carries a direction, a local-memory base address, a system-side base address, a byte length and a 4-bit tag. The block checks each request when it is pushed. Requests that are malformed are flagged and dropped. Requests that are legal are queued, unless the queue is full, in which case they are refused without any error.

A splitter takes one request at a time from the head of the queue and walks it in 128-byte lines, from the lowest address upward. Every line needs two operations, one command on the system-bus port and one access to the local memory, and the direction sets which of the two goes first. The local memory has a single port that the execution units also use. An arbiter favours the execution units but caps how long the DMA side can be kept waiting. When the last line of a request finishes, the block raises a one-cycle completion pulse that carries the request's tag.

Top module: `dma_line_queue`

## Requirements
- R1: The queue holds up to 16 accepted requests. While it is full, `push_full` is high and a legal push is refused (`push_accept` low, no `push_err`, nothing queued).
- R2: A push whose length is zero, is not a multiple of 128, or exceeds 16384 bytes is not queued, and `push_err` pulses high in the cycle after the push. A length of exactly 16384 is legal.
- R3: A push whose local or system address has any of its low 7 bits set is not queued, and `push_err` pulses high in the cycle after the push.
- R4: A request of length L produces L/128 lines. Line i uses local address `laddr+128*i` and system address `saddr+128*i`, and lines are issued in ascending order. A bus command is held with a stable address until `bus_ready` accepts it.
- R5: Direction 1 (out of local memory): each line first reads local memory (`lm_we`=0), then issues a bus command with `bus_write`=1. Direction 0 (into local memory): each line first issues a bus command with `bus_write`=0, then writes local memory (`lm_we`=1).
- R6: Requests are processed strictly in push order, and a request's first line is issued only after the previous request's last line.
- R7: The local-memory port serves at most one requester per cycle. An execution-unit request with no DMA contention is granted in the same cycle, with `lm_addr`/`lm_we` taken from the execution unit.
- R8: When both sides request, the execution unit wins unless the DMA side has been denied for 4 consecutive cycles, in which case the DMA side wins that cycle. Under constant execution-unit demand, successive out-direction lines with the bus always ready are therefore 6 cycles apart.
- R9: `done_valid` is high for exactly one cycle, carrying the request's tag on `done_tag`, in the cycle after the last line's final operation completes.
- R10: After reset the queue is empty: no bus command, no DMA memory access, no completion pulse, `push_full` and `push_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Software offers a request this cycle |
| push_dir | input | 1 | 1 = local to system, 0 = system to local |
| push_laddr | input | 18 | Local-memory byte base address |
| push_saddr | input | 32 | System byte base address |
| push_len | input | 15 | Transfer length in bytes |
| push_tag | input | 4 | Tag returned on completion |
| push_accept | output | 1 | Request taken into the queue this cycle |
| push_full | output | 1 | Queue holds its maximum number of requests |
| push_err | output | 1 | Previous-cycle push was malformed |
| bus_valid | output | 1 | Line command on the system-bus port |
| bus_ready | input | 1 | System bus accepts the command |
| bus_write | output | 1 | 1 = line goes to system, 0 = line comes from system |
| bus_addr | output | 32 | System address of the line |
| eu_req | input | 1 | Execution unit requests local memory |
| eu_we | input | 1 | Execution-unit write enable |
| eu_addr | input | 18 | Execution-unit address |
| eu_gnt | output | 1 | Execution unit owns the memory port this cycle |
| lm_en | output | 1 | Local-memory access enable |
| lm_we | output | 1 | Local-memory write enable |
| lm_addr | output | 18 | Local-memory address |
| done_valid | output | 1 | A request has completed |
| done_tag | output | 4 | Tag of the completed request |

## Verification
The hardest state to reach from the ports is a full queue, because the splitter pops the head as soon as it is idle. The bench parks the splitter on an inbound line by holding `bus_ready` low, then pushes sixteen more requests and offers a seventeenth. The starvation limit is only visible when the execution unit demands the port without a break. The bench therefore holds `eu_req` high throughout an outbound transfer and measures the spacing between DMA grants.

// File: rtl/dlq_pkg.sv
package dlq_pkg;

    localparam int LADDR_W    = 18;
    localparam int SADDR_W    = 32;
    localparam int LEN_W      = 15;
    localparam int TAG_W      = 4;
    localparam int LINE_SHIFT = 7;
    localparam int LINE_BYTES = 1 << LINE_SHIFT;
    localparam int LINES_W    = LEN_W - LINE_SHIFT;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        SP_IDLE = 2'd0,
        SP_LM   = 2'd1,
        SP_BUS  = 2'd2
    } sp_state_e;

    typedef struct packed {
        dir_e                 dir;
        logic [LADDR_W-1:0]   laddr;
        logic [SADDR_W-1:0]   saddr;
        logic [LEN_W-1:0]     len;
        logic [TAG_W-1:0]     tag;
    } xfer_req_t;

    function automatic logic addr_line_aligned(input logic [SADDR_W-1:0] a);
        return a[LINE_SHIFT-1:0] == '0;
    endfunction

    function automatic logic len_legal(input logic [LEN_W-1:0] len, input int max_bytes);
        return (len != '0) && (len[LINE_SHIFT-1:0] == '0) && (int'(len) <= max_bytes);
    endfunction

endpackage

// File: rtl/dlq_fifo.sv
module dlq_fifo
    import dlq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  xfer_req_t din,
    input  logic      pop,
    output xfer_req_t dout,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    xfer_req_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (int'(count) == DEPTH);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= ptr_next(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) push |-> !full);  // R1
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);  // R6
    AST_COUNT_BOUND:  assert property (@(posedge clk) disable iff (rst) int'(count) <= DEPTH);  // R1

endmodule

// File: rtl/dlq_lm_arbiter.sv
module dlq_lm_arbiter #(
    parameter int STARVE_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic eu_req,
    input  logic dma_req,
    output logic eu_gnt,
    output logic dma_gnt
);
    localparam int CNT_W = $clog2(STARVE_LIMIT + 1);

    logic [CNT_W-1:0] deny_cnt;
    logic             dma_forced;

    assign dma_forced = (int'(deny_cnt) >= STARVE_LIMIT);

    always_comb begin
        eu_gnt  = 1'b0;
        dma_gnt = 1'b0;
        if (dma_req && (!eu_req || dma_forced)) begin
            dma_gnt = 1'b1;
        end else if (eu_req) begin
            eu_gnt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            deny_cnt <= '0;
        end else if (dma_req && !dma_gnt) begin
            if (!dma_forced) deny_cnt <= deny_cnt + 1'b1;
        end else begin
            deny_cnt <= '0;
        end
    end

    AST_GNT_ONEHOT:   assert property (@(posedge clk) disable iff (rst) $onehot0({eu_gnt, dma_gnt}));  // R7
    AST_STARVE_BOUND: assert property (@(posedge clk) disable iff (rst) int'(deny_cnt) <= STARVE_LIMIT);  // R8
    AST_EU_ALONE:     assert property (@(posedge clk) disable iff (rst) (eu_req && !dma_req) |-> eu_gnt);  // R7

endmodule

// File: rtl/dlq_splitter.sv
module dlq_splitter
    import dlq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  xfer_req_t          head,
    input  logic               head_valid,
    output logic               pop,
    output logic               bus_valid,
    input  logic               bus_ready,
    output logic               bus_write,
    output logic [SADDR_W-1:0] bus_addr,
    output logic               lm_req,
    input  logic               lm_gnt,
    output logic               lm_we,
    output logic [LADDR_W-1:0] lm_addr,
    output logic               done_valid,
    output logic [TAG_W-1:0]   done_tag
);
    sp_state_e          state;
    dir_e               cur_dir;
    logic [LADDR_W-1:0] cur_laddr;
    logic [SADDR_W-1:0] cur_saddr;
    logic [TAG_W-1:0]   cur_tag;
    logic [LINES_W-1:0] lines_left;
    logic               line_fin;
    sp_state_e          first_step;

    assign pop       = (state == SP_IDLE) && head_valid;
    assign bus_valid = (state == SP_BUS);
    assign bus_write = (cur_dir == DIR_OUT);
    assign bus_addr  = cur_saddr;
    assign lm_req    = (state == SP_LM);
    assign lm_we     = (cur_dir == DIR_IN);
    assign lm_addr   = cur_laddr;

    assign first_step = (cur_dir == DIR_OUT) ? SP_LM : SP_BUS;
    assign line_fin   = ((state == SP_LM)  && lm_gnt    && (cur_dir == DIR_IN)) ||
                        ((state == SP_BUS) && bus_ready && (cur_dir == DIR_OUT));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SP_IDLE;
            cur_dir    <= DIR_IN;
            cur_laddr  <= '0;
            cur_saddr  <= '0;
            cur_tag    <= '0;
            lines_left <= '0;
            done_valid <= 1'b0;
            done_tag   <= '0;
        end else begin
            done_valid <= 1'b0;
            if (line_fin) begin
                if (lines_left == LINES_W'(1)) begin
                    done_valid <= 1'b1;
                    done_tag   <= cur_tag;
                    state      <= SP_IDLE;
                end else begin
                    lines_left <= lines_left - 1'b1;
                    cur_laddr  <= cur_laddr + LADDR_W'(LINE_BYTES);
                    cur_saddr  <= cur_saddr + SADDR_W'(LINE_BYTES);
                    state      <= first_step;
                end
            end else begin
                case (state)
                    SP_IDLE: if (head_valid) begin
                        cur_dir    <= head.dir;
                        cur_laddr  <= head.laddr;
                        cur_saddr  <= head.saddr;
                        cur_tag    <= head.tag;
                        lines_left <= LINES_W'(head.len >> LINE_SHIFT);
                        state      <= (head.dir == DIR_OUT) ? SP_LM : SP_BUS;
                    end
                    SP_LM:   if (lm_gnt)    state <= SP_BUS;
                    SP_BUS:  if (bus_ready) state <= SP_LM;
                    default: state <= SP_IDLE;
                endcase
            end
        end
    end

    AST_BUS_HOLD:    assert property (@(posedge clk) disable iff (rst)
                         (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)));  // R4
    AST_LM_WAIT:     assert property (@(posedge clk) disable iff (rst)
                         (lm_req && !lm_gnt) |=> (lm_req && $stable(lm_addr)));  // R8
    AST_LINE_ALIGN:  assert property (@(posedge clk) disable iff (rst)
                         bus_valid |-> (bus_addr[LINE_SHIFT-1:0] == '0));  // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
                         done_valid |=> !done_valid);  // R9
    AST_POP_IDLE:    assert property (@(posedge clk) disable iff (rst)
                         pop |-> (!bus_valid && !lm_req));  // R6

endmodule

// File: rtl/dma_line_queue.sv
module dma_line_queue
    import dlq_pkg::*;
#(
    parameter int Q_DEPTH      = 16,
    parameter int MAX_BYTES    = 16384,
    parameter int STARVE_LIMIT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_valid,
    input  logic               push_dir,
    input  logic [LADDR_W-1:0] push_laddr,
    input  logic [SADDR_W-1:0] push_saddr,
    input  logic [LEN_W-1:0]   push_len,
    input  logic [TAG_W-1:0]   push_tag,
    output logic               push_accept,
    output logic               push_full,
    output logic               push_err,
    output logic               bus_valid,
    input  logic               bus_ready,
    output logic               bus_write,
    output logic [SADDR_W-1:0] bus_addr,
    input  logic               eu_req,
    input  logic               eu_we,
    input  logic [LADDR_W-1:0] eu_addr,
    output logic               eu_gnt,
    output logic               lm_en,
    output logic               lm_we,
    output logic [LADDR_W-1:0] lm_addr,
    output logic               done_valid,
    output logic [TAG_W-1:0]   done_tag
);
    xfer_req_t          in_req, head;
    logic               legal, q_empty, q_full, q_pop;
    logic               dma_req, dma_gnt, dma_we;
    logic [LADDR_W-1:0] dma_addr;

    assign in_req = '{dir:   dir_e'(push_dir),
                      laddr: push_laddr,
                      saddr: push_saddr,
                      len:   push_len,
                      tag:   push_tag};

    assign legal = len_legal(push_len, MAX_BYTES) &&
                   addr_line_aligned(SADDR_W'(push_laddr)) &&
                   addr_line_aligned(push_saddr);

    assign push_accept = push_valid && legal && !q_full;
    assign push_full   = q_full;

    always_ff @(posedge clk) begin
        if (rst) push_err <= 1'b0;
        else     push_err <= push_valid && !legal;
    end

    dlq_fifo #(.DEPTH(Q_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push_accept),
        .din   (in_req),
        .pop   (q_pop),
        .dout  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    dlq_splitter u_split (
        .clk        (clk),
        .rst        (rst),
        .head       (head),
        .head_valid (!q_empty),
        .pop        (q_pop),
        .bus_valid  (bus_valid),
        .bus_ready  (bus_ready),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .lm_req     (dma_req),
        .lm_gnt     (dma_gnt),
        .lm_we      (dma_we),
        .lm_addr    (dma_addr),
        .done_valid (done_valid),
        .done_tag   (done_tag)
    );

    dlq_lm_arbiter #(.STARVE_LIMIT(STARVE_LIMIT)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .eu_req  (eu_req),
        .dma_req (dma_req),
        .eu_gnt  (eu_gnt),
        .dma_gnt (dma_gnt)
    );

    assign lm_en   = eu_gnt || dma_gnt;
    assign lm_we   = dma_gnt ? dma_we   : eu_we;
    assign lm_addr = dma_gnt ? dma_addr : eu_addr;

    AST_ERR_NOT_QUEUED: assert property (@(posedge clk) disable iff (rst)
                            push_err |-> !$past(push_accept));  // R2
    AST_FULL_REFUSE:    assert property (@(posedge clk) disable iff (rst)
                            push_full |-> !push_accept);  // R1

endmodule

// File: tb/tb_dma_line_queue.sv
module tb_dma_line_queue;
    import dlq_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic               push_valid, push_dir;
    logic [LADDR_W-1:0] push_laddr;
    logic [SADDR_W-1:0] push_saddr;
    logic [LEN_W-1:0]   push_len;
    logic [TAG_W-1:0]   push_tag;
    logic               push_accept, push_full, push_err;
    logic               bus_valid, bus_ready, bus_write;
    logic [SADDR_W-1:0] bus_addr;
    logic               eu_req, eu_we;
    logic [LADDR_W-1:0] eu_addr;
    logic               eu_gnt, lm_en, lm_we;
    logic [LADDR_W-1:0] lm_addr;
    logic               done_valid;
    logic [TAG_W-1:0]   done_tag;

    always #5 clk = ~clk;

    dma_line_queue dut (.*);

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // expected line stream
    logic [SADDR_W-1:0] exp_saddr [1024];
    logic [LADDR_W-1:0] exp_laddr [1024];
    logic               exp_dir   [1024];
    int                 n_lines = 0;
    logic [TAG_W-1:0]   exp_tag   [128];
    int                 exp_end   [128];
    int                 n_req = 0;
    int bidx = 0, lidx = 0, didx = 0, last_evt = 0;
    int                 ready_mode = 0;
    logic               log_grants = 1'b0;
    int                 gcyc [16];
    int                 n_g = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bus_ready driver
    always @(negedge clk) begin
        case (ready_mode)
            0:       bus_ready <= 1'b1;
            1:       bus_ready <= (cyc % 3) != 0;
            default: bus_ready <= 1'b0;
        endcase
    end

    // monitor, sampled well before the rising edge
    always @(negedge clk) begin
        #3;
        if (!rst) begin
            if (bus_valid && bus_ready) begin
                chk(bus_addr == exp_saddr[bidx], "R4 bus line address", bus_addr, exp_saddr[bidx]);
                chk(bus_write == exp_dir[bidx], "R5 bus_write", bus_write, exp_dir[bidx]);
                if (exp_dir[bidx])
                    chk(lidx == bidx + 1, "R5 out: memory read before bus", lidx, bidx + 1);
                bidx++;
                last_evt = cyc;
            end
            if (lm_en && !eu_gnt) begin
                chk(lm_addr == exp_laddr[lidx], "R4 local line address", lm_addr, exp_laddr[lidx]);
                chk(lm_we == !exp_dir[lidx], "R5 lm_we", lm_we, !exp_dir[lidx]);
                if (!exp_dir[lidx])
                    chk(bidx == lidx + 1, "R5 in: bus before memory write", bidx, lidx + 1);
                if (log_grants && n_g < 16) begin
                    gcyc[n_g] = cyc;
                    n_g++;
                end
                lidx++;
                last_evt = cyc;
            end
            if (done_valid) begin
                chk(didx < n_req, "R6 unexpected completion", didx, n_req);
                chk(done_tag == exp_tag[didx], "R9 done_tag", done_tag, exp_tag[didx]);
                chk(bidx == exp_end[didx] && lidx == exp_end[didx], "R6 lines finished at done",
                    bidx, exp_end[didx]);
                chk(cyc == last_evt + 1, "R9 done one cycle after last line", cyc, last_evt + 1);
                didx++;
            end
        end
    end

    function automatic bit legal_req(input logic [LEN_W-1:0] len, input logic [LADDR_W-1:0] la,
                                     input logic [SADDR_W-1:0] sa);
        return (len != 0) && (len % 128 == 0) && (len <= 16384) && (la % 128 == 0) && (sa % 128 == 0);
    endfunction

    task automatic push(input logic d, input logic [LADDR_W-1:0] la, input logic [SADDR_W-1:0] sa,
                        input logic [LEN_W-1:0] len, input logic [TAG_W-1:0] tg,
                        input bit expect_full, input string req);
        bit lg, acc;
        lg = legal_req(len, la, sa);
        @(negedge clk);
        push_valid = 1'b1; push_dir = d; push_laddr = la; push_saddr = sa;
        push_len = len; push_tag = tg;
        #1;
        acc = push_accept;
        chk(acc == (lg && !expect_full), {req, " push_accept"}, acc, lg && !expect_full);
        if (acc) begin
            for (int i = 0; i < len / 128; i++) begin
                exp_saddr[n_lines] = sa + SADDR_W'(128 * i);
                exp_laddr[n_lines] = la + LADDR_W'(128 * i);
                exp_dir[n_lines]   = d;
                n_lines++;
            end
            exp_tag[n_req] = tg;
            exp_end[n_req] = n_lines;
            n_req++;
        end
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0;
        #1;
        chk(push_err == !lg, {req, " push_err"}, push_err, !lg);
    endtask

    task automatic drain();
        while (didx < n_req) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(didx == n_req, "R6 all requests completed", didx, n_req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", didx, n_req);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; push_valid = 1'b0; push_dir = 1'b0; push_laddr = '0; push_saddr = '0;
        push_len = '0; push_tag = '0; eu_req = 1'b0; eu_we = 1'b0; eu_addr = '0;
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        chk(!bus_valid && !lm_en && !done_valid, "R10 idle outputs in reset",
            {bus_valid, lm_en, done_valid}, 0);
        chk(!push_full && !push_err, "R10 flags in reset", {push_full, push_err}, 0);
        @(negedge clk);
        rst = 1'b0;

        // R2 / R3 malformed requests
        push(1, 18'h00100, 32'h1000_0000, 15'd0,     4'd1, 0, "R2 zero length");
        push(1, 18'h00100, 32'h1000_0000, 15'd100,   4'd1, 0, "R2 length not line multiple");
        push(1, 18'h00100, 32'h1000_0000, 15'd16512, 4'd1, 0, "R2 length above limit");
        push(0, 18'h00140, 32'h1000_0000, 15'd128,   4'd1, 0, "R3 local misaligned");
        push(0, 18'h00100, 32'h1000_0001, 15'd128,   4'd1, 0, "R3 system misaligned");
        repeat (4) @(negedge clk);
        chk(!bus_valid && !lm_en, "R2 R3 dropped requests issue nothing", {bus_valid, lm_en}, 0);

        // R7 execution unit alone
        @(negedge clk);
        eu_req = 1'b1; eu_we = 1'b1; eu_addr = 18'h2A80;
        #2;
        chk(eu_gnt && lm_en && lm_we && lm_addr == 18'h2A80, "R7 lone eu granted", lm_addr, 18'h2A80);
        @(negedge clk);
        eu_req = 1'b0; eu_we = 1'b0;

        // R4 R5 R6 sweep: both directions, 1..4 lines, two ready patterns
        for (int m = 0; m < 2; m++) begin
            ready_mode = m;
            for (int d = 0; d < 2; d++)
                for (int n = 1; n <= 4; n++)
                    push(d[0], LADDR_W'(n * 1024 + d * 512), 32'h8000_0000 + 32'(m * 65536 + n * 4096),
                         LEN_W'(n * 128), TAG_W'(n_req), 0, "R4 sweep");
            drain();
        end

        // R2 boundary: exactly 16 KB
        ready_mode = 0;
        push(1, 18'h10000, 32'h0004_0000, 15'd16384, 4'd9, 0, "R2 max length");
        drain();

        // R1 full queue
        ready_mode = 2;
        push(0, 18'h0, 32'h0010_0000, 15'd128, 4'd0, 0, "R1 parked head");
        repeat (3) @(negedge clk);
        for (int k = 1; k <= 16; k++)
            push(0, LADDR_W'(k * 128), 32'h0010_0000 + 32'(k * 128), 15'd128, TAG_W'(k), 0, "R1 fill");
        #1;
        chk(push_full, "R1 push_full after 16 queued", push_full, 1);
        push(0, 18'h3000, 32'h0020_0000, 15'd128, 4'd7, 1, "R1 refused while full");
        ready_mode = 0;
        drain();

        // R8 starvation limit under constant eu demand
        @(negedge clk);
        eu_req = 1'b1; eu_addr = 18'h0040; log_grants = 1'b1; n_g = 0;
        push(1, 18'h4000, 32'h0030_0000, 15'd384, 4'd12, 0, "R8 contended out");
        drain();
        eu_req = 1'b0; log_grants = 1'b0;
        chk(n_g == 3, "R8 dma grants under contention", n_g, 3);
        for (int g = 1; g < 3; g++)
            chk(gcyc[g] - gcyc[g-1] == 6, "R8 grant spacing", gcyc[g] - gcyc[g-1], 6);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule